// File: doc/BRIEF.md
# Comma Word Aligner with Bit-Slip Counter

This block sits directly behind a 20-bit deserializer and runs on the recovered word clock. The raw words it receives start at an arbitrary bit of the serial stream. The block shifts its view of the stream one bit at a time until a comma character lands in the first 10-bit code group of the word. It then delivers aligned 20-bit words, each holding two code groups. The number of bit positions it had to shift, 0 to 19, is brought out as a measurement value. A link-timing unit adds this value, multiplied by one bit time, to its coarse word-clock timestamp, which refines the delay measurement below one word period.

The search is a small state machine. `ST_SETTLE` waits a fixed number of words after every change of the slip value. `ST_HUNT` tests a single word at the current offset. `ST_CONFIRM` counts further consecutive comma hits at that offset. `ST_LOCKED` holds the offset and watches for a run of words without a comma. Transitions:
- settle-done (`ST_SETTLE`→`ST_HUNT`)
- hunt-hit (`ST_HUNT`→`ST_CONFIRM`)
- hunt-miss (`ST_HUNT`→`ST_SETTLE`, slip advanced)
- confirm-hit (stays in `ST_CONFIRM`, hit count raised)
- confirm-done (`ST_CONFIRM`→`ST_LOCKED`)
- confirm-miss (`ST_CONFIRM`→`ST_SETTLE`, slip advanced)
- lock-lost (`ST_LOCKED`→`ST_HUNT`, slip kept)
- restart (any state→`ST_SETTLE` with slip 0, taken on reset or on `resync_i`)

The environment asserts `resync_i` once clock recovery is in phase and the recovered clock is in use. It may assert `resync_i` again at any time to force a fresh alignment, and that alignment can end on a different slip value.

Top module: `comma_aligner`

## Requirements
- R1: During and right after reset, `locked_o` is 0, `slip_count_o` is 0 and `aligned_word_o` is all zeros while the raw input is zero.
- R2: Bit 19 of every word is the earliest bit in time. The word on `aligned_word_o` is the 20 stream bits that begin `slip_count_o` bits after the start of the raw word received one clock before the current one. It is registered, so it appears one clock after the raw word that completes it.
- R3: A comma is detected only when aligned bits [19:10] equal 0011111010 or 1100000101, written bit 19 down to bit 10. Comma patterns at any other position are not detected.
- R4: After each change of the slip value, 4 words pass before a word is tested. A word tested in `ST_HUNT` or `ST_CONFIRM` that holds no comma raises the slip value by exactly one.
- R5: `slip_count_o` never exceeds 19. A raise from 19 wraps to 0, and the search continues from there.
- R6: `locked_o` rises only after 3 consecutive tested words hold a comma at the same offset. After a restart on an aligned stream, the lock appears exactly 7 clocks after the clock edge that samples `resync_i`.
- R7: While locked, the slip value does not change. 7 consecutive words without a comma are tolerated. The 8th consecutive such word drops `locked_o`, and the search resumes at the same offset.
- R8: `resync_i` clears `locked_o` and sets `slip_count_o` to 0 on the next clock, then restarts the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_word_i | input | 20 | Unaligned deserializer word, bit 19 earliest |
| resync_i | input | 1 | Clear alignment and restart the search |
| aligned_word_o | output | 20 | Comma-aligned word, bit 19 earliest |
| locked_o | output | 1 | Alignment confirmed and held |
| slip_count_o | output | 5 | Applied bit offset, 0 to 19 |

## Verification
The stimulus is an idle stream of commas of alternating polarity, each followed by a data group. The stream is fed at random bit phases and also at phases 0, 1 and 5. Phase 1 needs the maximum slip of 19. Moving from phase 5 to phase 17 after lock forces the search to wrap from 19 through 0. A design that stops at 19, or that jumps the slip by more than one, ends on the wrong offset. The bench injects runs of exactly 7 and exactly 8 corrupted symbols, so a miss counter off by one either drops a healthy lock or keeps a lost one. A cycle-exact restart check catches a settle period or a hit count of the wrong length, because such a design asserts lock one or more clocks early or late.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int GROUP_W = 10;

    localparam logic [GROUP_W-1:0] COMMA_RD_NEG = 10'b0011111010;
    localparam logic [GROUP_W-1:0] COMMA_RD_POS = 10'b1100000101;

    typedef enum logic [1:0] {
        ST_SETTLE,
        ST_HUNT,
        ST_CONFIRM,
        ST_LOCKED
    } cal_state_e;

endpackage

// File: rtl/cal_shifter.sv
module cal_shifter #(
    parameter int WORD_W = 20,
    parameter int SLIP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_i,
    input  logic [SLIP_W-1:0] slip_i,
    output logic [WORD_W-1:0] aligned_o
);

    localparam int PAIR_W = 2 * WORD_W;

    logic [WORD_W-1:0] prev_q;
    logic [PAIR_W-1:0] pair;
    logic [PAIR_W-1:0] pair_sh;

    // earlier word in the upper half, so bit order follows time order
    always_comb begin
        pair    = {prev_q, raw_i};
        pair_sh = pair << slip_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            aligned_o <= '0;
        end else begin
            prev_q    <= raw_i;
            aligned_o <= pair_sh[PAIR_W-1 -: WORD_W];
        end
    end

endmodule

// File: rtl/cal_detect.sv
module cal_detect
    import cal_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);

    localparam int NUM_COMMA = 2;

    logic [GROUP_W-1:0] lead_group;
    logic [NUM_COMMA-1:0] match;

    assign lead_group = word_i[WORD_W-1 -: GROUP_W];

    for (genvar g = 0; g < NUM_COMMA; g++) begin : g_cmp
        localparam logic [GROUP_W-1:0] PATTERN = (g == 0) ? COMMA_RD_NEG : COMMA_RD_POS;
        assign match[g] = (lead_group == PATTERN);
    end

    assign hit_o = |match;

endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_pkg::*;
#(
    parameter int WORD_W       = 20,
    parameter int SETTLE_WORDS = 4,
    parameter int LOCK_HITS    = 3,
    parameter int LOSS_MISSES  = 8,
    parameter int SLIP_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resync_i,
    input  logic              hit_i,
    output logic [SLIP_W-1:0] slip_o,
    output logic              locked_o
);

    localparam int SC_W = $clog2(SETTLE_WORDS + 1);
    localparam int HC_W = $clog2(LOCK_HITS + 1);
    localparam int MC_W = $clog2(LOSS_MISSES + 1);

    localparam logic [SLIP_W-1:0] SLIP_LAST   = SLIP_W'(WORD_W - 1);
    localparam logic [SC_W-1:0]   SETTLE_LAST = SC_W'(SETTLE_WORDS - 1);
    localparam logic [HC_W-1:0]   HITS_LAST   = HC_W'(LOCK_HITS - 1);
    localparam logic [MC_W-1:0]   MISS_LAST   = MC_W'(LOSS_MISSES - 1);

    cal_state_e        state_q, state_d;
    logic [SLIP_W-1:0] slip_q, slip_d, slip_bump;
    logic [SC_W-1:0]   settle_q, settle_d;
    logic [HC_W-1:0]   hits_q, hits_d;
    logic [MC_W-1:0]   miss_q, miss_d;

    assign slip_bump = (slip_q == SLIP_LAST) ? '0 : slip_q + 1'b1;

    always_comb begin
        state_d  = state_q;
        slip_d   = slip_q;
        settle_d = settle_q;
        hits_d   = hits_q;
        miss_d   = miss_q;
        if (resync_i) begin
            state_d  = ST_SETTLE;
            slip_d   = '0;
            settle_d = '0;
            hits_d   = '0;
            miss_d   = '0;
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (settle_q == SETTLE_LAST) begin
                        state_d  = ST_HUNT;
                        settle_d = '0;
                    end else begin
                        settle_d = settle_q + 1'b1;
                    end
                end
                ST_HUNT: begin
                    if (hit_i) begin
                        state_d = (LOCK_HITS == 1) ? ST_LOCKED : ST_CONFIRM;
                        hits_d  = HC_W'(1);
                        miss_d  = '0;
                    end else begin
                        state_d  = ST_SETTLE;
                        slip_d   = slip_bump;
                        settle_d = '0;
                    end
                end
                ST_CONFIRM: begin
                    if (hit_i) begin
                        if (hits_q == HITS_LAST) begin
                            state_d = ST_LOCKED;
                            miss_d  = '0;
                        end else begin
                            hits_d = hits_q + 1'b1;
                        end
                    end else begin
                        state_d  = ST_SETTLE;
                        slip_d   = slip_bump;
                        settle_d = '0;
                        hits_d   = '0;
                    end
                end
                ST_LOCKED: begin
                    if (hit_i) begin
                        miss_d = '0;
                    end else if (miss_q == MISS_LAST) begin
                        state_d = ST_HUNT;
                        miss_d  = '0;
                        hits_d  = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
                default: state_d = ST_SETTLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SETTLE;
            slip_q   <= '0;
            settle_q <= '0;
            hits_q   <= '0;
            miss_q   <= '0;
        end else begin
            state_q  <= state_d;
            slip_q   <= slip_d;
            settle_q <= settle_d;
            hits_q   <= hits_d;
            miss_q   <= miss_d;
        end
    end

    always_comb begin
        locked_o = (state_q == ST_LOCKED);
        slip_o   = slip_q;
    end

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
    parameter int WORD_W       = 20,
    parameter int SETTLE_WORDS = 4,
    parameter int LOCK_HITS    = 3,
    parameter int LOSS_MISSES  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WORD_W-1:0]          raw_word_i,
    input  logic                       resync_i,
    output logic [WORD_W-1:0]          aligned_word_o,
    output logic                       locked_o,
    output logic [$clog2(WORD_W)-1:0]  slip_count_o
);

    localparam int SLIP_W = $clog2(WORD_W);

    logic comma_hit;

    cal_shifter #(
        .WORD_W (WORD_W),
        .SLIP_W (SLIP_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_i     (raw_word_i),
        .slip_i    (slip_count_o),
        .aligned_o (aligned_word_o)
    );

    cal_detect #(
        .WORD_W (WORD_W)
    ) u_detect (
        .word_i (aligned_word_o),
        .hit_o  (comma_hit)
    );

    cal_fsm #(
        .WORD_W       (WORD_W),
        .SETTLE_WORDS (SETTLE_WORDS),
        .LOCK_HITS    (LOCK_HITS),
        .LOSS_MISSES  (LOSS_MISSES),
        .SLIP_W       (SLIP_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync_i (resync_i),
        .hit_i    (comma_hit),
        .slip_o   (slip_count_o),
        .locked_o (locked_o)
    );

endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
    parameter int WORD_W = 20
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      resync,
    input logic                      hit,
    input logic                      locked,
    input logic [$clog2(WORD_W)-1:0] slip
);

    localparam int SLIP_W = $clog2(WORD_W);
    localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(WORD_W - 1);

    AST_SLIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slip <= SLIP_LAST); // R5

    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slip != $past(slip)) && !$past(resync)
        |-> slip == (($past(slip) == SLIP_LAST) ? '0 : $past(slip) + 1'b1)); // R4

    AST_RESYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !locked && (slip == '0)); // R8

    AST_LOCK_AFTER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(hit, 1) && $past(hit, 2) && $past(hit, 3)); // R6

    AST_SLIP_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) |-> $stable(slip)); // R7

endmodule

bind comma_aligner comma_aligner_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .resync (resync_i),
    .hit    (comma_hit),
    .locked (locked_o),
    .slip   (slip_count_o)
);

// File: tb/comma_aligner_bench.sv
`timescale 1ns/1ps
module comma_aligner_bench;

    localparam logic [9:0] CM_NEG   = 10'b0011111010;
    localparam logic [9:0] CM_POS   = 10'b1100000101;
    localparam logic [9:0] DATA_GRP = 10'b1010101010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] raw_word_i = '0;
    logic        resync_i = 1'b0;
    logic [19:0] aligned_word_o;
    logic        locked_o;
    logic [4:0]  slip_count_o;

    int compared = 0;
    int mismatched = 0;

    logic [19:0] sym_a = '0;
    logic [19:0] sym_b = '0;
    int          phase = 0;
    bit          pol = 1'b0;
    int          corrupt_left = 0;
    bit          saw_unlock = 1'b0;
    bit          done = 1'b0;
    int unsigned seed_val;

    always #4 clk = ~clk;

    comma_aligner u_comma_aligner (
        .clk            (clk),
        .rst_n          (rst_n),
        .raw_word_i     (raw_word_i),
        .resync_i       (resync_i),
        .aligned_word_o (aligned_word_o),
        .locked_o       (locked_o),
        .slip_count_o   (slip_count_o)
    );

    function automatic logic [19:0] window(input logic [19:0] a, input logic [19:0] b, input int sh);
        logic [39:0] p;
        p = {a, b} << sh;
        return p[39:20];
    endfunction

    function automatic logic [4:0] exp_slip(input int ph);
        return 5'((20 - ph) % 20);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_symbol();
        sym_a = sym_b;
        if (corrupt_left > 0) begin
            sym_b = '0;
            corrupt_left--;
        end else begin
            sym_b = {(pol ? CM_POS : CM_NEG), DATA_GRP};
        end
        pol = ~pol;
    endtask

    task automatic run_words(input int n, input bit pulse);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!locked_o) saw_unlock = 1'b1;
            resync_i   = pulse && (i == 0);
            raw_word_i = window(sym_a, sym_b, phase);
            next_symbol();
        end
    endtask

    task automatic check_aligned(input string req);
        bit ok;
        ok = (aligned_word_o[9:0] == DATA_GRP) &&
             ((aligned_word_o[19:10] == CM_NEG) || (aligned_word_o[19:10] == CM_POS));
        check(ok, req, aligned_word_o, {CM_NEG, DATA_GRP});
    endtask

    task automatic check_lock_at(input int ph, input string req);
        check(locked_o == 1'b1, req, locked_o, 1);
        check(slip_count_o == exp_slip(ph), req, slip_count_o, exp_slip(ph));
    endtask

    initial begin
        seed_val = $urandom(32'd7321);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(locked_o == 1'b0, "R1", locked_o, 0);
        check(slip_count_o == 5'd0, "R1", slip_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(aligned_word_o == '0, "R1", aligned_word_o, 0);
        check(locked_o == 1'b0, "R1", locked_o, 0);

        // R2/R3 phase 0: no slip needed
        phase = 0;
        run_words(1, 1'b1);
        run_words(200, 1'b0);
        check_lock_at(0, "R2");
        check_aligned("R3");
        run_words(1, 1'b0);
        check_aligned("R3");

        // R6 exact lock timing after restart on an aligned stream
        run_words(1, 1'b1);
        run_words(7, 1'b0);
        check(locked_o == 1'b0, "R6", locked_o, 0);
        check(slip_count_o == 5'd0, "R6", slip_count_o, 0);
        run_words(1, 1'b0);
        check(locked_o == 1'b1, "R6", locked_o, 1);

        // R5 maximum slip 19
        phase = 1;
        run_words(1, 1'b1);
        run_words(200, 1'b0);
        check_lock_at(1, "R5");
        check_aligned("R2");

        // R5 wrap: lock at 15, then move stream so 3 is needed
        phase = 5;
        run_words(1, 1'b1);
        run_words(200, 1'b0);
        check_lock_at(5, "R4");
        phase = 17;
        run_words(200, 1'b0);
        check_lock_at(17, "R5");
        check_aligned("R2");

        // R8 resync clears on the next clock
        run_words(1, 1'b1);
        run_words(1, 1'b0);
        check(locked_o == 1'b0, "R8", locked_o, 0);
        check(slip_count_o == 5'd0, "R8", slip_count_o, 0);
        run_words(200, 1'b0);
        check_lock_at(17, "R8");

        // R7 seven bad symbols tolerated
        saw_unlock = 1'b0;
        corrupt_left = 7;
        run_words(30, 1'b0);
        check(saw_unlock == 1'b0, "R7", saw_unlock, 0);
        check(slip_count_o == exp_slip(17), "R7", slip_count_o, exp_slip(17));

        // R7 eight bad symbols drop lock, then relock at same offset
        saw_unlock = 1'b0;
        corrupt_left = 8;
        run_words(30, 1'b0);
        check(saw_unlock == 1'b1, "R7", saw_unlock, 1);
        check_lock_at(17, "R7");

        // random phases with short corruption bursts
        for (int t = 0; t < 12; t++) begin
            phase = $urandom_range(0, 19);
            run_words(1, 1'b1);
            run_words(250, 1'b0);
            check_lock_at(phase, "R4");
            check_aligned("R2");
            saw_unlock = 1'b0;
            corrupt_left = $urandom_range(1, 7);
            run_words(30, 1'b0);
            check(saw_unlock == 1'b0, "R7", saw_unlock, 0);
            check_aligned("R3");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule